// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one byte into an asynchronous serial frame on a single output line. A small set of format inputs picks how many data bits go out (five to eight), whether one or two stop bits close the frame, and which of five parity behaviours applies. The format is captured together with the byte when the byte is taken, so the format inputs may change while a frame is on the line.

Bit timing comes from outside. A one-cycle strobe marks the end of each bit time, and the block moves the line to the next bit only on that strobe. A break request forces the line low at once. While the break is held no new byte is taken. After the request drops, the line stays low until the next strobe, so the break always ends on a bit-time boundary. Two status outputs tell apart "no byte is waiting to start" and "the line is fully idle".

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high, in_ready, tx_buf_empty and tx_line_idle are all 1.
- R2: A byte is taken on a clock edge where in_valid and in_ready are both 1. in_ready then stays 0 until the frame has fully ended, and it is 1 only when no frame is active and no break holds the line.
- R3: After a byte is taken, the line stays high until the next bit_tick edge, which starts the low start bit. After that the line changes only on clock edges where bit_tick is 1, and each such edge moves it to the next frame bit.
- R4: Data bits follow the start bit, least significant first. The data-length code cfg_len selects 0=5, 1=6, 2=7 and 3=8 bits, and the unused upper byte bits are never sent.
- R5: Stop bits are high and end the frame. cfg_two_stop=0 gives one stop bit and 1 gives two.
- R6: cfg_parity codes 0, 1, 2 and 3 send no parity bit. Code 4 sends odd parity and code 5 sends even parity, both computed over the configured data bits only. Code 6 sends a constant 1 and code 7 sends a constant 0. A parity bit sits right after the last data bit.
- R7: The format inputs are sampled when the byte is taken. Later changes to them do not alter the frame in progress.
- R8: While brk_req is 1 the line is low in the same cycle, in_ready is 0 and tx_line_idle is 0, whatever frame is in progress.
- R9: After brk_req returns to 0, the line stays low and in_ready stays 0 until the next bit_tick edge. A byte offered during the break is taken only after that edge.
- R10: tx_buf_empty is 0 from the edge that takes a byte until the edge that starts its start bit. tx_line_idle is 0 from the taking edge until the edge that ends the last stop bit.
- R11: The bit_tick edge that ends the last stop bit returns the block to idle: line high, in_ready 1, tx_line_idle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte can be taken this cycle |
| cfg_len | input | 2 | Data-length code |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_parity | input | 3 | Parity mode code |
| brk_req | input | 1 | Force break on the line |
| bit_tick | input | 1 | One-cycle end-of-bit-time strobe |
| txd | output | 1 | Serial line |
| tx_buf_empty | output | 1 | No byte waiting for its start bit |
| tx_line_idle | output | 1 | No frame active and no break on the line |

## Verification
If the bit index or the captured frame is corrupted, the wrong level shows on txd in the very bit time where it happens, because the line is sampled after every strobe across every length, stop and parity combination. If the last-bit index is wrong, the frame ends one strobe too early or too late, and in_ready and tx_line_idle show it at that strobe. A break hold register that clears too soon or too late shows as a high or low line in the cycle after brk_req falls, before the next strobe.

// File: rtl/utx_pkg.sv
package utx_pkg;

  localparam int unsigned MAX_DATA  = 8;
  localparam int unsigned FRAME_MAX = MAX_DATA + 4;  // start, data, parity, two stops
  localparam int unsigned IDX_W     = $clog2(FRAME_MAX);

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_SEND  = 2'd2
  } seq_state_t;

  // number of data bits for a length code
  function automatic int unsigned data_count(input logic [1:0] len_code);
    return 32'd5 + 32'(len_code);
  endfunction

  // parity codes with the top bit set carry a parity slot
  function automatic logic has_parity(input logic [2:0] par_code);
    return par_code[2];
  endfunction

  // index of the final stop bit within the frame
  function automatic int unsigned last_index(input logic [1:0] len_code,
                                             input logic       two_stop,
                                             input logic [2:0] par_code);
    return data_count(len_code) + 32'(has_parity(par_code)) + (two_stop ? 32'd2 : 32'd1);
  endfunction

  // parity slot value given the parity of the masked data ones
  function automatic logic parity_slot(input logic [2:0] par_code, input logic ones_odd);
    case (par_code[1:0])
      2'd0:    return ~ones_odd;  // odd total
      2'd1:    return ones_odd;   // even total
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/utx_frame_build.sv
module utx_frame_build #(
  parameter int unsigned MAX_DATA  = utx_pkg::MAX_DATA,
  parameter int unsigned FRAME_MAX = MAX_DATA + 4,
  parameter int unsigned IDX_W     = $clog2(FRAME_MAX)
) (
  input  logic [MAX_DATA-1:0]  data_in,
  input  logic [1:0]           len_code,
  input  logic                 two_stop,
  input  logic [2:0]           par_code,
  output logic [FRAME_MAX-1:0] frame_bits,
  output logic [IDX_W-1:0]     last_idx
);

  int unsigned         nd;
  logic [MAX_DATA-1:0] masked;
  logic                ones_odd;
  logic                par_bit;

  assign nd = utx_pkg::data_count(len_code);

  for (genvar g = 0; g < MAX_DATA; g++) begin : g_mask
    assign masked[g] = data_in[g] & (32'(g) < nd);
  end

  assign ones_odd = ^masked;
  assign par_bit  = utx_pkg::parity_slot(par_code, ones_odd);
  assign last_idx = IDX_W'(utx_pkg::last_index(len_code, two_stop, par_code));

  always_comb begin
    frame_bits    = '1;     // stop bits and padding high
    frame_bits[0] = 1'b0;   // start bit
    for (int i = 0; i < MAX_DATA; i++) begin
      if (32'(i) < nd) frame_bits[1 + i] = data_in[i];
    end
    if (utx_pkg::has_parity(par_code)) frame_bits[IDX_W'(nd + 1)] = par_bit;
  end

endmodule

// File: rtl/utx_brk_ctl.sv
module utx_brk_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_req,
  input  logic bit_tick,
  output logic line_low
);

  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= 1'b0;
    else if (brk_req)  hold_q <= 1'b1;
    else if (bit_tick) hold_q <= 1'b0;
  end

  assign line_low = brk_req | hold_q;

  AST_BREAK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !bit_tick) |=> line_low);  // R9

endmodule

// File: rtl/utx_bit_seq.sv
module utx_bit_seq #(
  parameter int unsigned FRAME_MAX = utx_pkg::FRAME_MAX,
  parameter int unsigned IDX_W     = $clog2(FRAME_MAX)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [FRAME_MAX-1:0] frame_in,
  input  logic [IDX_W-1:0]     last_in,
  input  logic                 bit_tick,
  output logic                 idle,
  output logic                 armed,
  output logic                 sending,
  output logic                 cur_bit,
  output logic                 start_evt,
  output logic                 done_evt
);

  import utx_pkg::*;

  seq_state_t           state_q;
  logic [FRAME_MAX-1:0] frame_q;
  logic [IDX_W-1:0]     last_q;
  logic [IDX_W-1:0]     idx_q;

  assign idle      = (state_q == SEQ_IDLE);
  assign armed     = (state_q == SEQ_ARMED);
  assign sending   = (state_q == SEQ_SEND);
  assign cur_bit   = frame_q[idx_q];
  assign start_evt = armed & bit_tick;
  assign done_evt  = sending & bit_tick & (idx_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      frame_q <= '1;
      last_q  <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (load) begin
          frame_q <= frame_in;
          last_q  <= last_in;
          state_q <= SEQ_ARMED;
        end
        SEQ_ARMED: if (bit_tick) begin
          idx_q   <= '0;
          state_q <= SEQ_SEND;
        end
        SEQ_SEND: if (bit_tick) begin
          if (idx_q == last_q) state_q <= SEQ_IDLE;
          else                 idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !bit_tick) |=> armed);  // R3
  AST_INDEX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && !bit_tick) |=> (sending && $stable(idx_q)));  // R3
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> idle);  // R11
  AST_LAST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (32'(last_q) >= 32'd6 && 32'(last_q) < FRAME_MAX));  // R5
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && idx_q == last_q) |-> cur_bit);  // R5

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int unsigned DATA_BITS = utx_pkg::MAX_DATA,
  localparam int unsigned FRAME_LEN = DATA_BITS + 4,
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DATA_BITS-1:0] in_data,
  output logic                 in_ready,
  input  logic [1:0]           cfg_len,
  input  logic                 cfg_two_stop,
  input  logic [2:0]           cfg_parity,
  input  logic                 brk_req,
  input  logic                 bit_tick,
  output logic                 txd,
  output logic                 tx_buf_empty,
  output logic                 tx_line_idle
);

  logic [FRAME_LEN-1:0] frame_bits;
  logic [IDX_W-1:0]     last_idx;
  logic                 line_low;
  logic                 seq_idle, seq_armed, seq_sending, seq_bit;
  logic                 start_evt, done_evt;
  logic                 accept;

  utx_frame_build #(.MAX_DATA(DATA_BITS), .FRAME_MAX(FRAME_LEN), .IDX_W(IDX_W)) u_build (
    .data_in    (in_data),
    .len_code   (cfg_len),
    .two_stop   (cfg_two_stop),
    .par_code   (cfg_parity),
    .frame_bits (frame_bits),
    .last_idx   (last_idx)
  );

  utx_brk_ctl u_brk (
    .clk      (clk),
    .rst_n    (rst_n),
    .brk_req  (brk_req),
    .bit_tick (bit_tick),
    .line_low (line_low)
  );

  utx_bit_seq #(.FRAME_MAX(FRAME_LEN), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .frame_in  (frame_bits),
    .last_in   (last_idx),
    .bit_tick  (bit_tick),
    .idle      (seq_idle),
    .armed     (seq_armed),
    .sending   (seq_sending),
    .cur_bit   (seq_bit),
    .start_evt (start_evt),
    .done_evt  (done_evt)
  );

  assign in_ready     = seq_idle & ~line_low;
  assign accept       = in_valid & in_ready;
  assign txd          = ~line_low & (~seq_sending | seq_bit);
  assign tx_buf_empty = ~seq_armed;
  assign tx_line_idle = seq_idle & ~line_low;

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !txd);  // R8
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!in_ready && !tx_line_idle && !tx_buf_empty));  // R2
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !brk_req) |=> !txd);  // R3
  AST_ARMED_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !brk_req) |=> txd);  // R3

endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic [1:0] cfg_len = '0;
  logic       cfg_two_stop = 1'b0;
  logic [2:0] cfg_parity = '0;
  logic       brk_req = 1'b0;
  logic       bit_tick = 1'b0;
  logic       txd, tx_buf_empty, tx_line_idle;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cfg_len(cfg_len), .cfg_two_stop(cfg_two_stop), .cfg_parity(cfg_parity),
    .brk_req(brk_req), .bit_tick(bit_tick), .txd(txd),
    .tx_buf_empty(tx_buf_empty), .tx_line_idle(tx_line_idle)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick_pulse();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  function automatic int frame_total(input int lc, input int st, input int pc);
    return 1 + (5 + lc) + ((pc >= 4) ? 1 : 0) + (st != 0 ? 2 : 1);
  endfunction

  function automatic logic exp_bit(input int k, input logic [7:0] d,
                                   input int lc, input int pc);
    int nd = 5 + lc;
    int ones = 0;
    if (k == 0) return 1'b0;
    if (k <= nd) return d[k-1];
    if (pc >= 4 && k == nd + 1) begin
      for (int i = 0; i < nd; i++) ones += int'(d[i]);
      case (pc)
        4: return ((ones % 2) == 0);
        5: return ((ones % 2) == 1);
        6: return 1'b1;
        default: return 1'b0;
      endcase
    end
    return 1'b1;
  endfunction

  task automatic offer(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    #1 chk("R2 ready before take", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 ready low after take", in_ready, 0);
    chk("R10 buf not empty", tx_buf_empty, 0);
    chk("R10 line busy", tx_line_idle, 0);
    chk("R3 line high while armed", txd, 1);
  endtask

  task automatic run_frame(input logic [7:0] d, input int lc, input int st, input int pc);
    int tot = frame_total(lc, st, pc);
    int nd = 5 + lc;
    for (int k = 0; k < tot; k++) begin
      tick_pulse();
      if (k == 0) begin
        chk("R3 start bit", txd, 0);
        chk("R10 buf empty at start", tx_buf_empty, 1);
      end else if (k <= nd) chk("R4 data bit", txd, exp_bit(k, d, lc, pc));
      else if (pc >= 4 && k == nd + 1) chk("R6 parity bit", txd, exp_bit(k, d, lc, pc));
      else chk("R5 stop bit", txd, 1);
      @(negedge clk);
      chk("R3 hold without tick", txd, exp_bit(k, d, lc, pc));
      chk("R2 ready low mid frame", in_ready, 0);
    end
    tick_pulse();
    chk("R11 line high at end", txd, 1);
    chk("R11 ready at end", in_ready, 1);
    chk("R11 idle at end", tx_line_idle, 1);
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h96};
    repeat (3) @(negedge clk);
    chk("R1 reset line", txd, 1);
    chk("R1 reset ready", in_ready, 1);
    chk("R1 reset buf empty", tx_buf_empty, 1);
    chk("R1 reset idle", tx_line_idle, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 line high after release", txd, 1);

    // full format sweep, format inputs scrambled after take (R7)
    for (int lc = 0; lc < 4; lc++)
      for (int st = 0; st < 2; st++)
        for (int pc = 0; pc < 8; pc++)
          for (int p = 0; p < 5; p++) begin
            cfg_len = 2'(lc); cfg_two_stop = st[0]; cfg_parity = 3'(pc);
            offer(pats[p]);
            cfg_len = ~cfg_len; cfg_two_stop = ~cfg_two_stop; cfg_parity = cfg_parity ^ 3'd5;
            @(negedge clk);
            chk("R3 armed waits for tick", txd, 1);
            run_frame(pats[p], lc, st, pc);
          end

    // break while idle, byte offered during break (R8, R9)
    cfg_len = 2'd3; cfg_two_stop = 1'b0; cfg_parity = 3'd0;
    @(negedge clk);
    brk_req = 1'b1;
    #1;
    chk("R8 line low on break", txd, 0);
    chk("R8 ready low on break", in_ready, 0);
    chk("R8 not idle on break", tx_line_idle, 0);
    in_valid = 1'b1; in_data = 8'h5A;
    tick_pulse();
    chk("R8 line low across tick", txd, 0);
    @(negedge clk) brk_req = 1'b0;
    @(negedge clk);
    chk("R9 line still low after release", txd, 0);
    chk("R9 ready still low after release", in_ready, 0);
    chk("R9 buf still empty", tx_buf_empty, 1);
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
    chk("R9 line high after tick", txd, 1);
    #1 chk("R9 ready after tick", in_ready, 1);
    @(negedge clk) in_valid = 1'b0;
    chk("R9 held byte taken", tx_buf_empty, 0);
    run_frame(8'h5A, 3, 0, 0);

    // break in the middle of a frame (R8)
    offer(8'hFF);
    tick_pulse(); tick_pulse();
    chk("R4 data high before break", txd, 1);
    @(negedge clk) brk_req = 1'b1;
    #1 chk("R8 break overrides frame", txd, 0);
    tick_pulse();
    chk("R8 low during frame break", txd, 0);
    @(negedge clk) brk_req = 1'b0;
    for (int i = 0; i < 14; i++) tick_pulse();
    chk("R11 idle after broken frame", tx_line_idle, 1);
    chk("R11 high after broken frame", txd, 1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule